// File: doc/BRIEF.md
# Multichannel ADC conversion sequencer

This block is the digital control core of a multichannel sampling converter. A host talks to it over a synchronous parallel bus. Each qualified write (`cs_i` and `wr_i` high at a clock edge) sets one addressed channel slot of a configuration store. Each slot holds an enable flag, a differential flag and a bipolar flag. When `inh_i` is low on a write, the write also starts a conversion cycle. All enabled channels are sampled at once through a one-cycle `sample_o` pulse. The block then converts them one at a time in ascending index order while `busy_no` is held low.

For each channel, the block raises `conv_req_o` with the channel index on `conv_ch_o` for a fixed number of clock cycles. On the last of those cycles it stores the 8-bit value presented on `conv_res_i` into an internal result memory. The front end drives `conv_res_i`; analog sampling and quantisation are outside this block.

Once `busy_no` is high again, the host reads results with read strobes taken while `inh_i` is low. Each read returns the next enabled channel's result and wraps back to the lowest enabled channel after the highest one. Repeating the start write with the same configuration gives a fresh set of results.

Top module: `adcseq_top`

## Requirements
- R1: After reset, `busy_no` is 1, `sample_o` and `conv_req_o` are 0, and `en_o`, `diff_o`, `bip_o` and `rdata_o` are all zero.
- R2: A write with `inh_i`=1 (while idle) updates slot `addr_i` on the next cycle. Data bit 0 sets the enable flag, bit 1 the differential flag and bit 2 the bipolar flag. It does not pulse `sample_o`, and `busy_no` stays 1.
- R3: A write with `inh_i`=0, where at least one channel is enabled after the write, has these effects on the next cycle:
  - `sample_o` is 1 for exactly one cycle.
  - `busy_no` goes to 0.
  - The enable flag of slot `addr_i` takes data bit 0.
- R4: On a write that starts a conversion, the differential and bipolar flags of every slot keep their previous values.
- R5: Enabled channels are converted in ascending index order. Each channel holds `conv_req_o`=1 with `conv_ch_o` set to its index for exactly CONV_CYCLES cycles. `conv_res_i` is captured on the last of those cycles.
- R6: `busy_no` stays 0 for exactly (number of enabled channels × CONV_CYCLES) cycles and then returns to 1.
- R7: A read strobe (`cs_i`, `rd_i`, `inh_i`=0, while idle) makes `rdata_o` show, on the next cycle, the result of the next enabled channel. The first read after a conversion returns the lowest enabled channel's result.
- R8: A read after the highest enabled channel's result wraps around and returns the lowest enabled channel's result.
- R9: Write and read strobes received while `busy_no` is 0 are ignored. They leave the configuration, the read position and `rdata_o` unchanged.
- R10: Strobes with `cs_i`=0, and read strobes with `inh_i`=1, have no effect on configuration, conversion, read position or `rdata_o`.
- R11: A start write that leaves no channel enabled starts nothing: `sample_o` stays 0 and `busy_no` stays 1.
- R12: A second start write with an unchanged configuration converts again, stores the new results, and resets the read position to the lowest enabled channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, qualifies write and read strobes |
| wr_i | input | 1 | Write strobe, one write per cycle when high |
| rd_i | input | 1 | Read strobe, one read per cycle when high |
| inh_i | input | 1 | Low on a write starts a conversion; must be low for reads |
| addr_i | input | ADDR_W | Configuration slot address |
| wdata_i | input | DATA_W | Write data: bit 0 enable, bit 1 differential, bit 2 bipolar |
| rdata_o | output | DATA_W | Read result, registered |
| busy_no | output | 1 | Low while a conversion cycle runs |
| sample_o | output | 1 | One-cycle pulse sampling all enabled channels |
| conv_req_o | output | 1 | Conversion request for the channel on conv_ch_o |
| conv_ch_o | output | ADDR_W | Index of the channel being converted |
| conv_res_i | input | DATA_W | Conversion result from the front end |
| en_o | output | NUM_CH | Per-channel enable flags |
| diff_o | output | NUM_CH | Per-channel differential flags |
| bip_o | output | NUM_CH | Per-channel bipolar flags |

## Verification
The bench builds the block with eight channels, 8-bit data and CONV_CYCLES set to 3. With these values, a seven-channel conversion with a gap at index 4 finishes in 21 cycles, so the skip over a disabled slot is exercised. The same short conversion leaves time to fire strobes in the middle of a busy window. Because seven of eight channels are enabled, the read wrap comes after a non-power-of-two count, and a full read sweep plus wrap fits in a few dozen cycles.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int unsigned CfgEnBit   = 0;
  localparam int unsigned CfgDiffBit = 1;
  localparam int unsigned CfgBipBit  = 2;
endpackage

// File: rtl/adcseq_ch_pick.sv
module adcseq_ch_pick #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned IDX_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [IDX_W-1:0]  cur_i,
  output logic [IDX_W-1:0]  first_o,
  output logic [IDX_W-1:0]  next_o,
  output logic              has_next_o,
  output logic              any_o
);
  always_comb begin
    first_o    = '0;
    next_o     = '0;
    has_next_o = 1'b0;
    // scan downward so the lowest match wins
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask_i[i]) first_o = IDX_W'(i);
      if (mask_i[i] && (i > int'(cur_i))) begin
        next_o     = IDX_W'(i);
        has_next_o = 1'b1;
      end
    end
    any_o = |mask_i;
  end
endmodule

// File: rtl/adcseq_cfg.sv
module adcseq_cfg
  import adcseq_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              inh_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] en_next_o,
  output logic [NUM_CH-1:0] diff_o,
  output logic [NUM_CH-1:0] bip_o
);
  logic [NUM_CH-1:0] en_q, diff_q, bip_q;

  always_comb begin
    en_next_o = en_q;
    if (we_i) en_next_o[addr_i] = wdata_i[CfgEnBit];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      diff_q <= '0;
      bip_q  <= '0;
    end else begin
      en_q <= en_next_o;
      // mode flags frozen on a start write
      if (we_i && inh_i) begin
        diff_q[addr_i] <= wdata_i[CfgDiffBit];
        bip_q[addr_i]  <= wdata_i[CfgBipBit];
      end
    end
  end

  assign en_o   = en_q;
  assign diff_o = diff_q;
  assign bip_o  = bip_q;

  // R4
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !inh_i) |=> ($stable(diff_o) && $stable(bip_o)));
  // R2
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && inh_i) |=> (diff_o[$past(addr_i)] == $past(wdata_i[CfgDiffBit])));
endmodule

// File: rtl/adcseq_conv_seq.sv
module adcseq_conv_seq #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CONV_CYCLES = 4,
  parameter int unsigned ADDR_W      = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [DATA_W-1:0] conv_res_i,
  output logic              busy_o,
  output logic              sample_o,
  output logic              conv_req_o,
  output logic [ADDR_W-1:0] conv_ch_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);
  localparam logic [CNT_W-1:0] CntLast = CNT_W'(CONV_CYCLES - 1);

  logic              busy_q, sample_q;
  logic [ADDR_W-1:0] ch_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [NUM_CH-1:0] mask_q, pick_mask;
  logic [ADDR_W-1:0] first_ch, next_ch;
  logic              has_next, any_en, last_cyc;

  assign pick_mask = busy_q ? mask_q : mask_i;
  assign last_cyc  = busy_q && (cnt_q == CntLast);

  adcseq_ch_pick #(.NUM_CH(NUM_CH), .IDX_W(ADDR_W)) u_pick (
    .mask_i     (pick_mask),
    .cur_i      (ch_q),
    .first_o    (first_ch),
    .next_o     (next_ch),
    .has_next_o (has_next),
    .any_o      (any_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sample_q <= 1'b0;
      ch_q     <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else begin
      sample_q <= 1'b0;
      if (!busy_q) begin
        if (start_i && any_en) begin
          busy_q   <= 1'b1;
          sample_q <= 1'b1;
          ch_q     <= first_ch;
          cnt_q    <= '0;
          mask_q   <= mask_i;
        end
      end else if (last_cyc) begin
        cnt_q <= '0;
        if (has_next) ch_q <= next_ch;
        else          busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o     = busy_q;
  assign sample_o   = sample_q;
  assign conv_req_o = busy_q;
  assign conv_ch_o  = ch_q;
  assign ram_we_o   = last_cyc;
  assign ram_addr_o = ch_q;
  assign ram_data_o = conv_res_i;

  // R3
  sample_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  // R3
  sample_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> sample_o);
  // R5
  ch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !ram_we_o) |=> (conv_req_o && $stable(conv_ch_o)));
  // R5
  ch_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> mask_q[conv_ch_o]);
endmodule

// File: rtl/adcseq_result_ram.sv
module adcseq_result_ram #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ptr_rst_i,
  input  logic              rd_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] words [NUM_CH];
  logic [ADDR_W-1:0] rptr_q, first_ch, next_ch;
  logic [DATA_W-1:0] rdata_q;
  logic              has_next, any_en;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  word_q <= '0;
      else if (we_i && (waddr_i == ADDR_W'(g)))    word_q <= wdata_i;
    end
    assign words[g] = word_q;
  end

  adcseq_ch_pick #(.NUM_CH(NUM_CH), .IDX_W(ADDR_W)) u_pick (
    .mask_i     (mask_i),
    .cur_i      (rptr_q),
    .first_o    (first_ch),
    .next_o     (next_ch),
    .has_next_o (has_next),
    .any_o      (any_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rdata_q <= '0;
    end else if (ptr_rst_i) begin
      rptr_q <= first_ch;
    end else if (rd_i) begin
      rdata_q <= words[rptr_q];
      if (any_en) rptr_q <= has_next ? next_ch : first_ch;
    end
  end

  assign rdata_o = rdata_q;

  // R9
  rd_while_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !we_i);
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CONV_CYCLES = 4,
  parameter int unsigned ADDR_W      = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              inh_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_no,
  output logic              sample_o,
  output logic              conv_req_o,
  output logic [ADDR_W-1:0] conv_ch_o,
  input  logic [DATA_W-1:0] conv_res_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] diff_o,
  output logic [NUM_CH-1:0] bip_o
);
  logic              busy, wr_go, rd_go, start;
  logic [NUM_CH-1:0] en_next;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_data;

  assign wr_go = cs_i && wr_i && !busy;
  assign rd_go = cs_i && rd_i && !inh_i && !busy;
  assign start = wr_go && !inh_i;

  adcseq_cfg #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_go),
    .inh_i     (inh_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .en_o      (en_o),
    .en_next_o (en_next),
    .diff_o    (diff_o),
    .bip_o     (bip_o)
  );

  adcseq_conv_seq #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES),
                    .ADDR_W(ADDR_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .mask_i     (en_next),
    .conv_res_i (conv_res_i),
    .busy_o     (busy),
    .sample_o   (sample_o),
    .conv_req_o (conv_req_o),
    .conv_ch_o  (conv_ch_o),
    .ram_we_o   (ram_we),
    .ram_addr_o (ram_addr),
    .ram_data_o (ram_data)
  );

  adcseq_result_ram #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ram_we),
    .waddr_i   (ram_addr),
    .wdata_i   (ram_data),
    .ptr_rst_i (sample_o),
    .rd_i      (rd_go),
    .mask_i    (en_o),
    .rdata_o   (rdata_o)
  );

  assign busy_no = !busy;

  // R9
  busy_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |=> ($stable(en_o) && $stable(diff_o) && $stable(bip_o)));
  // R10
  nocs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && busy_no) |=> ($stable(en_o) && $stable(rdata_o) && busy_no));
  // R11
  empty_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && wr_i && !inh_i && busy_no && (en_next == '0)) |=> (busy_no && !sample_o));
endmodule

// File: tb/sim_adcseq_top.sv
module sim_adcseq_top;
  localparam int NCH = 8;
  localparam int DW  = 8;
  localparam int CC  = 3;
  localparam int AW  = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, inh_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o, conv_res_i;
  logic          busy_no, sample_o, conv_req_o;
  logic [AW-1:0] conv_ch_o;
  logic [NCH-1:0] en_o, diff_o, bip_o;

  int n_cmp = 0, n_bad = 0, run = 0;
  logic rd_chk = 1'b0, rd_seen = 1'b0;
  int    exp_q[$];
  string req_q[$];

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] res_of(int r, int ch);
    return 8'(r * 40 + ch * 7 + 3);
  endfunction

  assign conv_res_i = res_of(run, int'(conv_ch_o));

  adcseq_top #(.NUM_CH(NCH), .DATA_W(DW), .CONV_CYCLES(CC)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .wr_i(wr_i), .rd_i(rd_i),
    .inh_i(inh_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .busy_no(busy_no), .sample_o(sample_o), .conv_req_o(conv_req_o),
    .conv_ch_o(conv_ch_o), .conv_res_i(conv_res_i), .en_o(en_o),
    .diff_o(diff_o), .bip_o(bip_o));

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d, logic inh, logic cs = 1'b1);
    @(negedge clk_i);
    cs_i = cs; wr_i = 1'b1; inh_i = inh; addr_i = AW'(a); wdata_i = DW'(d);
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0; inh_i = 1'b1;
  endtask

  // driver: pushes expected item when the read is meant to take effect
  task automatic rd(int exp, string req, logic push = 1'b1, logic cs = 1'b1,
                    logic inh = 1'b0);
    @(negedge clk_i);
    cs_i = cs; rd_i = 1'b1; inh_i = inh;
    if (push) begin
      exp_q.push_back(exp);
      req_q.push_back(req);
      rd_chk = 1'b1;
    end
    @(negedge clk_i);
    cs_i = 1'b0; rd_i = 1'b0; inh_i = 1'b1; rd_chk = 1'b0;
  endtask

  // monitor
  always @(posedge clk_i) rd_seen <= rd_chk;
  always @(negedge clk_i) begin
    if (rd_seen && exp_q.size() > 0) begin
      int e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(r, int'(rdata_o), e);
    end
  end

  task automatic conv_check(int seq[$], string req);
    bit ok = 1'b1;
    foreach (seq[j]) begin
      for (int k = 0; k < CC; k++) begin
        if (!(conv_req_o && int'(conv_ch_o) == seq[j] && !busy_no)) ok = 1'b0;
        @(negedge clk_i);
      end
    end
    chk({req, " R5 order/length"}, int'(ok), 1);
    chk({req, " R6 busy release"}, int'(busy_no), 1);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int order[$] = '{0, 1, 2, 3, 5, 6, 7};
    logic [DW-1:0] held;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 busy_no", int'(busy_no), 1);
    chk("R1 sample/req", int'({sample_o, conv_req_o}), 0);
    chk("R1 cfg", int'({en_o, diff_o, bip_o}), 0);
    chk("R1 rdata", int'(rdata_o), 0);

    // start with nothing enabled
    wr(0, 0, 1'b0);
    chk("R11 sample", int'(sample_o), 0);
    chk("R11 busy_no", int'(busy_no), 1);
    @(negedge clk_i);
    chk("R11 busy_no later", int'(busy_no), 1);

    // configuration: bit0 enable, bit1 diff, bit2 bipolar
    wr(0, 3, 1'b1);
    chk("R2 slot0", int'({en_o[0], diff_o[0], bip_o[0]}), 3'b110);
    chk("R2 no sample", int'(sample_o), 0);
    wr(1, 1, 1'b1);
    wr(2, 5, 1'b1);
    wr(3, 1, 1'b1);
    wr(5, 7, 1'b1);
    wr(7, 1, 1'b1);
    chk("R2 en", int'(en_o), 'hAF);
    chk("R2 diff", int'(diff_o), 'h21);
    chk("R2 bip", int'(bip_o), 'h24);
    chk("R2 busy_no", int'(busy_no), 1);

    // start on the last configuration write, mode bits must be ignored
    run = 1;
    wr(6, 7, 1'b0);
    chk("R3 sample", int'(sample_o), 1);
    chk("R3 busy_no", int'(busy_no), 0);
    chk("R3 en updated", int'(en_o), 'hEF);
    conv_check(order, "run1");
    chk("R4 diff kept", int'(diff_o), 'h21);
    chk("R4 bip kept", int'(bip_o), 'h24);

    // readback and wrap
    foreach (order[j]) rd(int'(res_of(1, order[j])), "R7 readback");
    rd(int'(res_of(1, 0)), "R8 wrap lowest");
    rd(int'(res_of(1, 1)), "R8 wrap next");
    @(negedge clk_i);
    held = rdata_o;

    // ignored strobes
    rd(0, "", 1'b0, 1'b0, 1'b0);
    chk("R10 cs low read", int'(rdata_o), int'(held));
    rd(0, "", 1'b0, 1'b1, 1'b1);
    chk("R10 inh high read", int'(rdata_o), int'(held));
    wr(4, 7, 1'b1, 1'b0);
    chk("R10 cs low write", int'({en_o, diff_o, bip_o}), int'({8'hEF, 8'h21, 8'h24}));
    wr(4, 1, 1'b0, 1'b0);
    chk("R10 cs low start", int'({busy_no, sample_o}), 2'b10);
    rd(int'(res_of(1, 2)), "R10 pointer kept");
    @(negedge clk_i);
    held = rdata_o;

    // second run, same configuration, strobes during busy
    run = 2;
    wr(0, 1, 1'b0);
    chk("R12 restart busy_no", int'(busy_no), 0);
    wr(4, 7, 1'b1);
    rd(0, "", 1'b0);
    for (int t = 0; t < 40 && !busy_no; t++) @(negedge clk_i);
    chk("R9 en kept", int'(en_o), 'hEF);
    chk("R9 diff kept", int'(diff_o), 'h21);
    chk("R9 rdata kept", int'(rdata_o), int'(held));
    rd(int'(res_of(2, 0)), "R12 pointer reset");
    rd(int'(res_of(2, 1)), "R12 new result");
    rd(int'(res_of(2, 2)), "R9 ram intact");
    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule